// File: doc/BRIEF.md
# Wired-Floor Random Replacement Index Generator

This block supplies the slot number that a translation buffer uses when software asks for a write into an arbitrary entry. A down-counter moves one step on most clock cycles. When it reaches a programmable floor, called the wired boundary here, its next step returns it to the highest entry instead of going lower. Entries numbered below the boundary are therefore never offered for replacement, so mappings placed there stay resident.

A 10-bit linear feedback shift register runs on every cycle. On cycles when its top bit is set, the counter skips its step. This breaks any fixed phase relation between the counter and a software loop that polls it at a regular interval. Software sets the boundary through a single write port. Each boundary write also sends the counter back to the top entry.

Top module: `repl_index_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the index reads the maximum entry (15 for 16 entries), the boundary is 0, and the shift register holds the seed 10'h001.
- R2: On a cycle with no boundary write, a boundary below the maximum, a clear shift-register top bit and an index above the boundary, the index drops by exactly one at the next clock.
- R3: The shift register state s[9:0] advances every cycle as {s[8:0], s[9]^s[6]} (polynomial x^10 + x^7 + 1). When s[9] is 1 in a cycle that has no boundary write and a boundary below the maximum, the index keeps its value at the next clock.
- R4: When the index equals the boundary, the shift-register top bit is clear, and there is no write, the next index is the maximum entry.
- R5: The index is never below the current boundary value.
- R6: A boundary write captures the 4-bit data as the new boundary and makes the next index the maximum entry.
- R7: While the boundary is equal to or above the maximum entry, the index stays at the maximum.
- R8: With a boundary of 0, the index reaches 0 and then wraps to 15.
- R9: The shift register keeps stepping during boundary writes and while the index is pinned, so the skip pattern does not depend on either.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wiredWe | input | 1 | Boundary write strobe |
| wiredData | input | 4 | New boundary value |
| randIdx | output | 4 | Current replacement index |

## Verification
The bench predicts every cycle from its own model of the shift register, so a wrong tap, a wrong seed, or a skip tied to the wrong bit shows up as a mismatch in the first few dozen cycles. It looks for the wrap at the boundary under several floor values, including 0, where a design that wraps at zero or one step too late would emit an index below the floor or repeat the floor. Boundary writes made in the middle of a run check that the index returns to the top and that the skip pattern keeps its phase. A boundary of 15 checks the pinned case, where a design that still decrements would expose protected entries.

// File: rtl/repl_index_pkg.sv
package repl_index_pkg;

  localparam int LFSR_W   = 10;
  localparam int TAP_HI   = 9;
  localparam int TAP_LO   = 6;

  typedef struct packed {
    logic load;
    logic wrap;
    logic dec;
  } idxStrobes_t;

  function automatic logic [LFSR_W-1:0] lfsrStep(input logic [LFSR_W-1:0] cur);
    return {cur[LFSR_W-2:0], cur[TAP_HI] ^ cur[TAP_LO]};
  endfunction

endpackage

// File: rtl/repl_index_ctrl.sv
module repl_index_ctrl
  import repl_index_pkg::*;
#(
  parameter logic [LFSR_W-1:0] LFSR_SEED = 10'h001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wiredWe,
  input  logic              atFloor,
  input  logic              pinned,
  output idxStrobes_t       strobes,
  output logic [LFSR_W-1:0] lfsrState
);

  logic [LFSR_W-1:0] lfsrQ;
  logic              skipNow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsrQ <= LFSR_SEED;
    else        lfsrQ <= lfsrStep(lfsrQ);
  end

  assign skipNow = lfsrQ[LFSR_W-1];

  always_comb begin
    strobes = '0;
    if (wiredWe || pinned) begin
      strobes.load = 1'b1;
    end else if (!skipNow) begin
      if (atFloor) strobes.wrap = 1'b1;
      else         strobes.dec  = 1'b1;
    end
  end

  assign lfsrState = lfsrQ;

endmodule

// File: rtl/repl_index_dp.sv
module repl_index_dp
  import repl_index_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  idxStrobes_t      strobes,
  input  logic             wiredWe,
  input  logic [IDX_W-1:0] wiredData,
  output logic [IDX_W-1:0] randIdx,
  output logic [IDX_W-1:0] wiredQ,
  output logic             atFloor,
  output logic             pinned
);

  localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(NUM_ENTRIES - 1);

  logic [IDX_W-1:0] idxQ;
  logic [IDX_W-1:0] idxNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wiredQ <= '0;
    else if (wiredWe) wiredQ <= wiredData;
  end

  always_comb begin
    idxNext = idxQ;
    if (strobes.load || strobes.wrap) idxNext = MAX_IDX;
    else if (strobes.dec)             idxNext = idxQ - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idxQ <= MAX_IDX;
    else        idxQ <= idxNext;
  end

  assign atFloor = (idxQ <= wiredQ);
  assign pinned  = (wiredQ >= MAX_IDX);
  assign randIdx = idxQ;

endmodule

// File: rtl/repl_index_gen.sv
module repl_index_gen
  import repl_index_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 10'h001,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wiredWe,
  input  logic [IDX_W-1:0] wiredData,
  output logic [IDX_W-1:0] randIdx
);

  idxStrobes_t       strobes;
  logic [LFSR_W-1:0] lfsrState;
  logic [IDX_W-1:0]  wiredQ;
  logic              atFloor;
  logic              pinned;

  repl_index_ctrl #(.LFSR_SEED(LFSR_SEED)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wiredWe   (wiredWe),
    .atFloor   (atFloor),
    .pinned    (pinned),
    .strobes   (strobes),
    .lfsrState (lfsrState)
  );

  repl_index_dp #(.NUM_ENTRIES(NUM_ENTRIES)) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .wiredWe   (wiredWe),
    .wiredData (wiredData),
    .randIdx   (randIdx),
    .wiredQ    (wiredQ),
    .atFloor   (atFloor),
    .pinned    (pinned)
  );

endmodule

// File: rtl/repl_index_gen_chk.sv
module repl_index_gen_chk
  import repl_index_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wiredWe,
  input logic [IDX_W-1:0]  wiredData,
  input logic [IDX_W-1:0]  randIdx,
  input logic [IDX_W-1:0]  wiredQ,
  input logic [LFSR_W-1:0] lfsrState
);

  localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(NUM_ENTRIES - 1);

  a_r6_write_loads_max: assert property (@(posedge clk) disable iff (!rst_n)
    wiredWe |=> (randIdx == MAX_IDX && wiredQ == $past(wiredData)));

  a_r5_never_below_floor: assert property (@(posedge clk) disable iff (!rst_n)
    randIdx >= wiredQ);

  a_r7_pinned_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    (!wiredWe && wiredQ >= MAX_IDX) |=> randIdx == MAX_IDX);

  a_r3_skip_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!wiredWe && wiredQ < MAX_IDX && lfsrState[LFSR_W-1]) |=> $stable(randIdx));

  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!wiredWe && wiredQ < MAX_IDX && !lfsrState[LFSR_W-1] && randIdx > wiredQ)
      |=> randIdx == $past(randIdx) - 1'b1);

  a_r4_wrap_at_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (!wiredWe && wiredQ < MAX_IDX && !lfsrState[LFSR_W-1] && randIdx == wiredQ)
      |=> randIdx == MAX_IDX);

  a_r9_lfsr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (lfsrState != '0 && lfsrState[LFSR_W-1:1] == $past(lfsrState[LFSR_W-2:0])));

endmodule

bind repl_index_gen repl_index_gen_chk #(.NUM_ENTRIES(NUM_ENTRIES)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .wiredWe   (wiredWe),
  .wiredData (wiredData),
  .randIdx   (randIdx),
  .wiredQ    (wiredQ),
  .lfsrState (lfsrState)
);

// File: tb/repl_index_gen_tb_top.sv
module repl_index_gen_tb_top;

  localparam int NUM_VEC = 6;
  localparam int WIRED_V [NUM_VEC] = '{0, 5, 14, 15, 9, 3};
  localparam int RUN_V   [NUM_VEC] = '{60, 50, 20, 12, 40, 70};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wiredWe = 1'b0;
  logic [3:0] wiredData = '0;
  logic [3:0] randIdx;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [9:0] mL;
  logic [3:0] mI;
  logic [3:0] mW;
  bit sawZero;
  bit sawZeroWrap;

  always #2.5 clk = ~clk;

  repl_index_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wiredWe(wiredWe),
    .wiredData(wiredData), .randIdx(randIdx)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic tick();
    logic [9:0] nL;
    logic [3:0] nI;
    logic [3:0] nW;
    string tag;
    logic [3:0] prevI;
    nL = {mL[8:0], mL[9] ^ mL[6]};
    nW = mW;
    nI = mI;
    prevI = mI;
    if (wiredWe) begin nW = wiredData; nI = 4'd15; tag = "R6"; end
    else if (mW >= 4'd15) begin nI = 4'd15; tag = "R7"; end
    else if (mL[9]) begin nI = mI; tag = "R3"; end
    else if (mI <= mW) begin nI = 4'd15; tag = "R4"; end
    else begin nI = mI - 4'd1; tag = "R2"; end
    @(posedge clk);
    @(negedge clk);
    mL = nL; mI = nI; mW = nW;
    check(tag, int'(randIdx), int'(mI));
    check("R5", int'(randIdx >= mW), 1);
    if (mW == 0 && mI == 0) sawZero = 1;
    if (mW == 0 && prevI == 0 && mI == 15 && tag == "R4") sawZeroWrap = 1;
  endtask

  task automatic writeWired(input int val);
    wiredData = 4'(val);
    wiredWe = 1'b1;
    tick();
    wiredWe = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    mL = 10'h001; mI = 4'd15; mW = 4'd0;
    sawZero = 0; sawZeroWrap = 0;
    repeat (3) @(negedge clk);
    check("R1", int'(randIdx), 15);
    rst_n = 1'b1;
    check("R1", int'(randIdx), 15);

    // no write yet: boundary 0 from reset, run through a full wrap
    for (int c = 0; c < 80; c++) tick();
    check("R8", int'(sawZero), 1);
    check("R8", int'(sawZeroWrap), 1);

    // table walk: write a boundary, then run
    for (int v = 0; v < NUM_VEC; v++) begin
      writeWired(WIRED_V[v]);
      check("R6", int'(randIdx), 15);
      for (int c = 0; c < RUN_V[v]; c++) tick();
    end

    // write in mid-run, then back-to-back writes: skip phase must persist (R9)
    writeWired(2);
    for (int c = 0; c < 7; c++) tick();
    writeWired(4);
    writeWired(15);
    for (int c = 0; c < 5; c++) tick();
    check("R7", int'(randIdx), 15);
    writeWired(1);
    for (int c = 0; c < 60; c++) tick();
    check("R9", int'(randIdx >= 1), 1);

    // reset in mid-run restores state (R1)
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", int'(randIdx), 15);
    @(negedge clk);
    rst_n = 1'b1;
    mL = 10'h001; mI = 4'd15; mW = 4'd0;
    for (int c = 0; c < 40; c++) tick();

    summary();
  end

endmodule